// File: doc/BRIEF.md
# Paged Memory Module Chip-Select Decoder

This block sits between a 24-bit address, 16-bit data system bus and a 1 MB memory module. The module is eight banks of 64K x 16, and each bank is two 64K x 8 byte-lane devices. The module's window starts at byte address 0x0C0000 and ends at 0x1BFFFF. That start is not a power of two, so the block subtracts the base from the bus address and checks the result against the window size. Bits 19:17 of the difference pick the bank. Address bit 0 and an active-low byte-high enable pick the byte lanes, so the bus can make full 16-bit transfers as well as single-byte transfers on either lane.

The block also does the following:
- It passes word-address bits 16:1 to every bank.
- It drives one shared write strobe to the devices.
- It enables the data buffers and sets their direction, so that data goes onto the bus during reads.
- It raises an error flag when both bus commands are active at once.

All outputs are registered. They show the inputs sampled at the previous rising clock edge.

Top module: `busdec_top`

## Requirements
- R1: While reset (rstN low) is active, and right after it, modSelN, devWrN, bufEnN and every bit of csLoN and csHiN are 1. cmdErr, bufToBus and wordAddr are 0.
- R2: One clock edge after the inputs are sampled, modSelN is 0 if and only if exactly one of memRdN or memWrN is 0 and busAddr lies in 0x0C0000..0x1BFFFF inclusive. Until that edge, the outputs keep their previous values.
- R3: The selected bank is i = bits 19:17 of (busAddr - 0x0C0000), and only bit i of csLoN and csHiN may be 0. At most one bit of each vector is 0.
- R4: When the module is selected, csLoN[i] is 0 when busAddr[0] is 0, and csHiN[i] is 0 when byteHiEnN is 0. When busAddr[0] is 1 and byteHiEnN is 1, no chip select is active.
- R5: With both memRdN and memWrN high, every chip select, modSelN, bufEnN and devWrN stay 1, whatever the address.
- R6: With memRdN and memWrN both low, cmdErr is 1 at any address. No chip select is active, and modSelN, bufEnN and devWrN are 1.
- R7: wordAddr equals busAddr[16:1] sampled at the previous edge, whatever the command or the range.
- R8: devWrN is 0 exactly when the module is selected for a write (memWrN is 0).
- R9: bufEnN equals modSelN. bufToBus is 1 exactly when the module is selected for a read (memRdN is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 24 | Byte address from the bus |
| byteHiEnN | input | 1 | High byte-lane enable, active low |
| memRdN | input | 1 | Memory read command, active low |
| memWrN | input | 1 | Memory write command, active low |
| modSelN | output | 1 | Module selected, active low |
| csLoN | output | 8 | Low-lane chip select per bank, active low |
| csHiN | output | 8 | High-lane chip select per bank, active low |
| wordAddr | output | 16 | Word address sent to all banks |
| devWrN | output | 1 | Write strobe to the devices, active low |
| bufEnN | output | 1 | Data buffer enable, active low |
| bufToBus | output | 1 | Buffer direction, 1 drives data onto the bus |
| cmdErr | output | 1 | Both commands active at once |

## Verification
The range check and the command-conflict check can both fire in the same cycle. This happens when both commands are driven low with an address inside the window. The bench applies that case at the module's base address and again at an address outside the window. In both cases it expects the conflict to win: the error flag is set, the module select is off and no lane is selected. A second overlap is a byte access that passes the range check but asks for no lane (A0 = 1, high enable off). There the bench expects the module to be selected, with both chip-select vectors all ones.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

  // number of bank-index bits; eight banks by default
  localparam int BANK_IDX_W = 3;

  // strobes handed from the control decode to the datapath registers
  typedef struct packed {
    logic                  inWindow;  // address falls inside the module window
    logic                  rdGo;      // read command alone
    logic                  wrGo;      // write command alone
    logic                  conflict;  // both commands together
    logic                  laneLo;    // low byte lane requested
    logic                  laneHi;    // high byte lane requested
    logic [BANK_IDX_W-1:0] bank;      // bank index from the window offset
  } selStrobe_t;

endpackage

// File: rtl/busdec_ctrl.sv
module busdec_ctrl
  import busdec_pkg::*;
#(
  parameter int          ADDR_W      = 24,
  parameter int          WORD_ADDR_W = 16,
  parameter logic [23:0] BASE_ADDR   = 24'h0C0000
) (
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              byteHiEnN,
  input  logic              memRdN,
  input  logic              memWrN,
  output selStrobe_t        strobeOut
);

  localparam int NUM_BANKS = 1 << BANK_IDX_W;
  localparam int BANK_LSB  = WORD_ADDR_W + 1;
  // module window size in bytes, one bit wider than the address
  localparam logic [ADDR_W:0] SPAN = (ADDR_W + 1)'(NUM_BANKS) << BANK_LSB;
  localparam logic [ADDR_W:0] BASE_EXT = (ADDR_W + 1)'(BASE_ADDR);

  logic [ADDR_W:0] offset;

  // a borrow sets the top bit, so an address below the base fails the compare
  always_comb begin
    offset = {1'b0, addrIn} - BASE_EXT;
  end

  always_comb begin
    strobeOut          = '0;
    strobeOut.inWindow = (offset < SPAN);
    strobeOut.rdGo     = !memRdN && memWrN;
    strobeOut.wrGo     = !memWrN && memRdN;
    strobeOut.conflict = !memRdN && !memWrN;
    strobeOut.laneLo   = !addrIn[0];
    strobeOut.laneHi   = !byteHiEnN;
    strobeOut.bank     = offset[BANK_LSB +: BANK_IDX_W];
  end

endmodule

// File: rtl/busdec_dp.sv
module busdec_dp
  import busdec_pkg::*;
#(
  parameter int WORD_ADDR_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  selStrobe_t             strobeIn,
  input  logic [WORD_ADDR_W-1:0] addrWord,
  output logic                   modSelN,
  output logic [(1<<BANK_IDX_W)-1:0] csLoN,
  output logic [(1<<BANK_IDX_W)-1:0] csHiN,
  output logic [WORD_ADDR_W-1:0] wordAddr,
  output logic                   devWrN,
  output logic                   bufEnN,
  output logic                   bufToBus,
  output logic                   cmdErr
);

  localparam int NUM_BANKS = 1 << BANK_IDX_W;

  logic                 selNxt;
  logic [NUM_BANKS-1:0] csLoNxt;
  logic [NUM_BANKS-1:0] csHiNxt;

  always_comb begin
    selNxt = strobeIn.inWindow && (strobeIn.rdGo || strobeIn.wrGo);
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    localparam logic [BANK_IDX_W-1:0] IDX = BANK_IDX_W'(g);
    always_comb begin
      csLoNxt[g] = !(selNxt && strobeIn.laneLo && (strobeIn.bank == IDX));
      csHiNxt[g] = !(selNxt && strobeIn.laneHi && (strobeIn.bank == IDX));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modSelN  <= 1'b1;
      csLoN    <= '1;
      csHiN    <= '1;
      wordAddr <= '0;
      devWrN   <= 1'b1;
      bufEnN   <= 1'b1;
      bufToBus <= 1'b0;
      cmdErr   <= 1'b0;
    end else begin
      modSelN  <= !selNxt;
      csLoN    <= csLoNxt;
      csHiN    <= csHiNxt;
      wordAddr <= addrWord;
      devWrN   <= !(selNxt && strobeIn.wrGo);
      bufEnN   <= !selNxt;
      bufToBus <= selNxt && strobeIn.rdGo;
      cmdErr   <= strobeIn.conflict;
    end
  end

  // R3: at most one bank per lane
  assert_lane_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csLoN) && $onehot0(~csHiN));

  // R2: a chip select only under module select
  assert_cs_needs_sel_R2: assert property (@(posedge clk) disable iff (!rstN)
    (((~csLoN) | (~csHiN)) != '0) |-> !modSelN);

  // R6: a conflicting command raises the flag and selects nothing
  assert_conflict_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobeIn.conflict |=> (cmdErr && (&csLoN) && (&csHiN) && bufEnN && devWrN));

  // R5: no command, no selection
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeIn.rdGo && !strobeIn.wrGo && !strobeIn.conflict)
      |=> (modSelN && (&csLoN) && (&csHiN) && devWrN));

  // R7: word address follows the bus one edge later
  assert_word_addr_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobeIn.inWindow |=> (wordAddr == $past(addrWord)));

  // R9: direction toward the bus only with the buffers enabled
  assert_buf_dir_R9: assert property (@(posedge clk) disable iff (!rstN)
    bufToBus |-> (!bufEnN && !modSelN));

  // R8: write strobe only on a selected transfer that is not a read
  assert_wr_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    !devWrN |-> (!modSelN && !bufToBus));

endmodule

// File: rtl/busdec_top.sv
module busdec_top
  import busdec_pkg::*;
#(
  parameter int          ADDR_W      = 24,
  parameter int          WORD_ADDR_W = 16,
  parameter logic [23:0] BASE_ADDR   = 24'h0C0000
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        byteHiEnN,
  input  logic                        memRdN,
  input  logic                        memWrN,
  output logic                        modSelN,
  output logic [(1<<BANK_IDX_W)-1:0]  csLoN,
  output logic [(1<<BANK_IDX_W)-1:0]  csHiN,
  output logic [WORD_ADDR_W-1:0]      wordAddr,
  output logic                        devWrN,
  output logic                        bufEnN,
  output logic                        bufToBus,
  output logic                        cmdErr
);

  selStrobe_t strobe;

  busdec_ctrl #(
    .ADDR_W      (ADDR_W),
    .WORD_ADDR_W (WORD_ADDR_W),
    .BASE_ADDR   (BASE_ADDR)
  ) uCtrl (
    .addrIn    (busAddr),
    .byteHiEnN (byteHiEnN),
    .memRdN    (memRdN),
    .memWrN    (memWrN),
    .strobeOut (strobe)
  );

  busdec_dp #(
    .WORD_ADDR_W (WORD_ADDR_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobeIn (strobe),
    .addrWord (busAddr[WORD_ADDR_W:1]),
    .modSelN  (modSelN),
    .csLoN    (csLoN),
    .csHiN    (csHiN),
    .wordAddr (wordAddr),
    .devWrN   (devWrN),
    .bufEnN   (bufEnN),
    .bufToBus (bufToBus),
    .cmdErr   (cmdErr)
  );

endmodule

// File: tb/sim_busdec_top.sv
`timescale 1ns/1ps
module sim_busdec_top;

  localparam real CLK_HALF = 4.0;  // 125 MHz
  localparam int  NVEC     = 14;

  // layout: addr[33:10] bheN[9] rdN[8] wrN[7] sel[6] bank[5:3] lo[2] hi[1] err[0]
  localparam logic [33:0] VEC [NVEC] = '{
    {24'h0C0000, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0}, // base, word read
    {24'h0BFFFF, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0}, // just below
    {24'h1BFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 3'd7, 1'b0, 1'b1, 1'b0}, // last byte, high lane write
    {24'h1C0000, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0}, // just above
    {24'h0E0000, 1'b1, 1'b0, 1'b1, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0}, // low byte only
    {24'h0E0001, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0, 1'b1, 1'b0}, // high byte only
    {24'h0E0001, 1'b1, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0}, // no lane asked
    {24'h150000, 1'b0, 1'b1, 1'b0, 1'b1, 3'd4, 1'b1, 1'b1, 1'b0}, // mid window write
    {24'h17FFFE, 1'b1, 1'b0, 1'b1, 1'b1, 3'd5, 1'b1, 1'b0, 1'b0}, // bank 5 low read
    {24'h0C0000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1}, // conflict in window
    {24'h000100, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1}, // conflict outside
    {24'h0D2346, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0}, // no command
    {24'hFFFFFF, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0}, // top of space
    {24'h1A0000, 1'b0, 1'b1, 1'b0, 1'b1, 3'd7, 1'b1, 1'b1, 1'b0}  // bank 7 word write
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] busAddr = '0;
  logic        byteHiEnN = 1'b1;
  logic        memRdN = 1'b1;
  logic        memWrN = 1'b1;
  logic        modSelN, devWrN, bufEnN, bufToBus, cmdErr;
  logic [7:0]  csLoN, csHiN;
  logic [15:0] wordAddr;

  int  nChecks = 0;
  int  nBad = 0;
  bit  finished = 0;

  always #(CLK_HALF) clk = ~clk;

  busdec_top u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .byteHiEnN(byteHiEnN),
    .memRdN(memRdN), .memWrN(memWrN), .modSelN(modSelN), .csLoN(csLoN),
    .csHiN(csHiN), .wordAddr(wordAddr), .devWrN(devWrN), .bufEnN(bufEnN),
    .bufToBus(bufToBus), .cmdErr(cmdErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  endtask

  task automatic checkIdle(input string tag);
    chk({tag, " modSelN"}, 32'(modSelN), 32'h1);
    chk({tag, " csLoN"}, 32'(csLoN), 32'hFF);
    chk({tag, " csHiN"}, 32'(csHiN), 32'hFF);
    chk({tag, " devWrN"}, 32'(devWrN), 32'h1);
    chk({tag, " bufEnN"}, 32'(bufEnN), 32'h1);
    chk({tag, " bufToBus"}, 32'(bufToBus), 32'h0);
    chk({tag, " cmdErr"}, 32'(cmdErr), 32'h0);
  endtask

  initial begin
    #(CLK_HALF * 2 * 150000);
    nChecks++;
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    checkIdle("R1 in reset");
    chk("R1 wordAddr", 32'(wordAddr), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 after release");

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [33:0] e;
      logic [7:0]  expLo, expHi;
      e = VEC[v];
      busAddr   = e[33:10];
      byteHiEnN = e[9];
      memRdN    = e[8];
      memWrN    = e[7];
      @(negedge clk);
      expLo = e[2] ? ~(8'h01 << e[5:3]) : 8'hFF;
      expHi = e[1] ? ~(8'h01 << e[5:3]) : 8'hFF;
      chk("R2 modSelN", 32'(modSelN), 32'(!e[6]));
      chk("R3 R4 csLoN", 32'(csLoN), 32'(expLo));
      chk("R3 R4 csHiN", 32'(csHiN), 32'(expHi));
      chk("R6 cmdErr", 32'(cmdErr), 32'(e[0]));
      chk("R7 wordAddr", 32'(wordAddr), 32'(e[26:11]));
      chk("R8 devWrN", 32'(devWrN), 32'(!(e[6] && !e[7])));
      chk("R9 bufEnN", 32'(bufEnN), 32'(!e[6]));
      chk("R9 bufToBus", 32'(bufToBus), 32'(e[6] && !e[8]));
      if (e[8] && e[7]) chk("R5 idle select", 32'(modSelN), 32'h1);
    end

    // R2: a new input is not seen before the next rising edge
    busAddr = 24'h0C0002; byteHiEnN = 1'b0; memRdN = 1'b0; memWrN = 1'b1;
    @(negedge clk);
    chk("R2 settled sel", 32'(modSelN), 32'h0);
    busAddr = 24'h0C0002; memRdN = 1'b1; memWrN = 1'b1;
    #(CLK_HALF / 2);
    chk("R2 held before edge", 32'(csLoN), 32'hFE);
    @(negedge clk);
    chk("R2 after edge", 32'(csLoN), 32'hFF);

    // R6: conflict at the window edge, then a clean write to the same place
    busAddr = 24'h1BFFFE; memRdN = 1'b0; memWrN = 1'b0;
    @(negedge clk);
    chk("R6 edge conflict err", 32'(cmdErr), 32'h1);
    chk("R6 edge conflict cs", 32'({csLoN, csHiN}), 32'hFFFF);
    memRdN = 1'b1;
    @(negedge clk);
    chk("R6 err clears", 32'(cmdErr), 32'h0);
    chk("R8 write after conflict", 32'(devWrN), 32'h0);
    chk("R3 bank7 both lanes", 32'({csLoN, csHiN}), 32'h7F7F);

    // R1: reset in the middle of a selected transfer
    #1;
    rstN = 1'b0;
    #1;
    checkIdle("R1 mid-run reset");
    @(negedge clk);
    rstN = 1'b1;
    memWrN = 1'b1;
    @(negedge clk);

    finishRun();
  end

endmodule